// File: doc/BRIEF.md
# Glyph Row Address Scheduler for Sprite Text

This block feeds a bank of character sprites during each horizontal blanking interval. It fetches the code points for one text row from a message memory, holds them, and then turns each into a font memory address for the glyph row that sprite will draw next. Both memories sit outside the block. Each has a synchronous read with one cycle of latency.

When the blanking interval starts, the block runs a fixed, staggered schedule across the sprite slots. Slot i has its message memory address driven at X = H_ACTIVE+i. The returned code point is captured at X = H_ACTIVE+i+1. At X = H_ACTIVE+i+2 the slot's strobe rises and the font address is driven. Every slot uses the same two memory ports, one slot per cycle. The same eight sprites draw a second text row lower on the screen: from the second-row Y threshold onward, each slot takes its character from the upper half of the 16-entry message.

An internal counter picks the message shown. It counts frame starts and moves to the next message after a set number of frames. After the last message it returns to the first. The index changes only at a frame start, so no frame ever shows part of one message and part of another.

Top module: `glyph_feed_top`

## Requirements
- R1: After reset the message index is 0. While X lies outside the schedule window, `msg_addr`, `font_addr` and `slot_strobe` are all 0.
- R2: When Y is below ROW2_Y and X equals H_ACTIVE+i (i = 0..7), `msg_addr` equals index*16 + i.
- R3: When Y is at or above ROW2_Y and X equals H_ACTIVE+i, `msg_addr` equals index*16 + i + 8.
- R4: For any X other than H_ACTIVE..H_ACTIVE+7, `msg_addr` is 0.
- R5: Bit i of `slot_strobe` is high exactly when X equals H_ACTIVE+i+2. At most one bit is high in any cycle.
- R6: While bit i of `slot_strobe` is high, `font_addr` equals (c − 0x20)*8 + r_i. Here c is the code point the message memory returned for slot i's fetch on that line, and r_i is bits [3i+2:3i] of `row_idx`.
- R7: While no strobe bit is high, `font_addr` is 0.
- R8: Each cycle with X = 0 and Y = 0 counts one frame start. After every FRAMES_PER_MSG frame starts the message index goes up by one, and from 31 it goes to 0.
- R9: The message index changes only in the cycle that follows a frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| sx | input | 10 | Current horizontal screen position |
| sy | input | 10 | Current vertical screen position |
| row_idx | input | 24 | Glyph row currently needed by each sprite, 3 bits per slot, slot 0 in the LSBs |
| msg_rdata | input | 7 | Code point returned by the message memory |
| msg_addr | output | 9 | Message memory read address |
| font_addr | output | 9 | Font memory read address |
| slot_strobe | output | 8 | One-hot per-sprite strobe marking the cycle its font row address is on the bus |
| msg_idx | output | 5 | Message currently selected |

## Verification
If a slot's decode goes wrong, the fault shows on the address bus within the same blanking interval. It appears as a stray or shifted `msg_addr`, or as a strobe in the wrong cycle. A code-point register that captures in the wrong cycle shows two cycles later: the font address carries a neighbour's glyph. A fault in the frame counter or the message rotator appears in `msg_idx` after the first FRAMES_PER_MSG frame starts. It then offsets every message address on the next line by a multiple of 16. The bench sweeps blanking on rows above, at and below the second-row threshold, and it repeats the sweep after rotation and after the wrap.

// File: rtl/glyph_feed_pkg.sv
package glyph_feed_pkg;

    // Lowest code point present in the font
    localparam int CP_FIRST = 'h20;

    // Font row address for one slot: glyph number times glyph height plus row
    function automatic int unsigned glyph_row_addr(
        input int unsigned cp,
        input int unsigned row,
        input int unsigned glyph_h,
        input int unsigned glyphs
    );
        int unsigned gidx;
        gidx = (cp - CP_FIRST) % glyphs;
        return gidx * glyph_h + row;
    endfunction

endpackage

// File: rtl/glyph_slot_decode.sv
module glyph_slot_decode #(
    parameter int CW       = 10,
    parameter int H_ACTIVE = 640,
    parameter int SLOTS    = 8
) (
    input  logic [CW-1:0]    sx,
    output logic [SLOTS-1:0] fetch_sel,
    output logic [SLOTS-1:0] latch_sel,
    output logic [SLOTS-1:0] issue_sel
);
    // Three staggered compare points per slot
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam logic [CW-1:0] FETCH_X = CW'(H_ACTIVE + i);
        localparam logic [CW-1:0] LATCH_X = CW'(H_ACTIVE + i + 1);
        localparam logic [CW-1:0] ISSUE_X = CW'(H_ACTIVE + i + 2);
        assign fetch_sel[i] = (sx == FETCH_X);
        assign latch_sel[i] = (sx == LATCH_X);
        assign issue_sel[i] = (sx == ISSUE_X);
    end
endmodule

// File: rtl/glyph_cp_bank.sv
module glyph_cp_bank #(
    parameter int SLOTS = 8,
    parameter int CP_W  = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SLOTS-1:0]      latch_sel,
    input  logic [CP_W-1:0]       msg_rdata,
    output logic [SLOTS*CP_W-1:0] cp_flat
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_cp
        logic [CP_W-1:0] cp_q;
        always_ff @(posedge clk) begin
            if (rst)
                cp_q <= '0;
            else if (latch_sel[i])
                cp_q <= msg_rdata;
        end
        assign cp_flat[i*CP_W +: CP_W] = cp_q;
    end
endmodule

// File: rtl/glyph_msg_rotator.sv
module glyph_msg_rotator #(
    parameter int MSG_COUNT      = 32,
    parameter int FRAMES_PER_MSG = 80,
    localparam int IDX_W         = $clog2(MSG_COUNT),
    localparam int FC_W          = $clog2(FRAMES_PER_MSG + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    output logic [IDX_W-1:0] msg_idx
);
    localparam logic [FC_W-1:0]  FC_LAST  = FC_W'(FRAMES_PER_MSG - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(MSG_COUNT - 1);

    logic [FC_W-1:0] frame_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_cnt <= '0;
            msg_idx   <= '0;
        end else if (frame_start) begin
            if (frame_cnt == FC_LAST) begin
                frame_cnt <= '0;
                msg_idx   <= (msg_idx == IDX_LAST) ? '0 : msg_idx + 1'b1;
            end else begin
                frame_cnt <= frame_cnt + 1'b1;
            end
        end
    end

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_start) |-> $stable(msg_idx)); // R9

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(msg_idx) == IDX_LAST && !$stable(msg_idx)) |-> msg_idx == '0); // R8
endmodule

// File: rtl/glyph_feed_top.sv
module glyph_feed_top
    import glyph_feed_pkg::*;
#(
    parameter int CW             = 10,
    parameter int H_ACTIVE       = 640,
    parameter int ROW2_Y         = 248,
    parameter int SLOTS          = 8,
    parameter int MSG_COUNT      = 32,
    parameter int MSG_LEN        = 16,
    parameter int CP_W           = 7,
    parameter int GLYPHS         = 64,
    parameter int GLYPH_H        = 8,
    parameter int FRAMES_PER_MSG = 80,
    localparam int ROW_W         = $clog2(GLYPH_H),
    localparam int MA_W          = $clog2(MSG_COUNT * MSG_LEN),
    localparam int FA_W          = $clog2(GLYPHS * GLYPH_H),
    localparam int IDX_W         = $clog2(MSG_COUNT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          sx,
    input  logic [CW-1:0]          sy,
    input  logic [SLOTS*ROW_W-1:0] row_idx,
    input  logic [CP_W-1:0]        msg_rdata,
    output logic [MA_W-1:0]        msg_addr,
    output logic [FA_W-1:0]        font_addr,
    output logic [SLOTS-1:0]       slot_strobe,
    output logic [IDX_W-1:0]       msg_idx
);
    localparam logic [CW-1:0] ROW2_Y_C = CW'(ROW2_Y);

    logic [SLOTS-1:0]      fetch_sel, latch_sel, issue_sel;
    logic [SLOTS*CP_W-1:0] cp_flat;
    logic                  frame_start;
    logic                  lower_row;
    logic [MA_W-1:0]       msg_base;

    glyph_slot_decode #(
        .CW(CW), .H_ACTIVE(H_ACTIVE), .SLOTS(SLOTS)
    ) u_decode (
        .sx(sx), .fetch_sel(fetch_sel), .latch_sel(latch_sel), .issue_sel(issue_sel)
    );

    glyph_cp_bank #(
        .SLOTS(SLOTS), .CP_W(CP_W)
    ) u_cp (
        .clk(clk), .rst(rst), .latch_sel(latch_sel), .msg_rdata(msg_rdata), .cp_flat(cp_flat)
    );

    assign frame_start = (sx == '0) && (sy == '0);

    glyph_msg_rotator #(
        .MSG_COUNT(MSG_COUNT), .FRAMES_PER_MSG(FRAMES_PER_MSG)
    ) u_rot (
        .clk(clk), .rst(rst), .frame_start(frame_start), .msg_idx(msg_idx)
    );

    assign lower_row = (sy >= ROW2_Y_C);
    assign msg_base  = MA_W'(msg_idx) * MA_W'(MSG_LEN);

    // Message memory address: one slot per cycle, 0 when idle
    always_comb begin
        msg_addr = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (fetch_sel[i])
                msg_addr = msg_base + MA_W'(i) + (lower_row ? MA_W'(SLOTS) : '0);
        end
    end

    // Font memory address: held code point plus the sprite's current row
    always_comb begin
        font_addr = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (issue_sel[i])
                font_addr = FA_W'(glyph_row_addr(
                    int'(cp_flat[i*CP_W +: CP_W]),
                    int'(row_idx[i*ROW_W +: ROW_W]),
                    GLYPH_H, GLYPHS));
        end
    end

    assign slot_strobe = issue_sel;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_strobe)); // R5

    AST_FONT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (slot_strobe == '0) |-> (font_addr == '0)); // R7

    AST_MSG_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fetch_sel == '0) |-> (msg_addr == '0)); // R4

    AST_STROBE_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
        (latch_sel[0] && sx != '1) |-> (slot_strobe == '0)); // R5
endmodule

// File: tb/glyph_feed_top_test.sv
module glyph_feed_top_test;
    localparam int H_ACTIVE = 640;
    localparam int ROW2_Y   = 248;
    localparam int SLOTS    = 8;
    localparam int FRAMES   = 2;
    localparam int MSGS     = 32;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  sx, sy;
    logic [23:0] row_idx;
    logic [6:0]  msg_rdata;
    logic [8:0]  msg_addr, font_addr;
    logic [7:0]  slot_strobe;
    logic [4:0]  msg_idx;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_idx  = 0;
    int exp_fcnt = 0;

    logic [6:0] msg_mem [512];

    always #2.5 clk = ~clk;

    glyph_feed_top #(.FRAMES_PER_MSG(FRAMES)) uut (
        .clk(clk), .rst(rst), .sx(sx), .sy(sy), .row_idx(row_idx),
        .msg_rdata(msg_rdata), .msg_addr(msg_addr), .font_addr(font_addr),
        .slot_strobe(slot_strobe), .msg_idx(msg_idx)
    );

    // Message memory model, one-cycle synchronous read
    always @(posedge clk) msg_rdata <= msg_mem[msg_addr];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int x, input int y);
        @(negedge clk);
        sx = 10'(x);
        sy = 10'(y);
        #1;
    endtask

    task automatic test_reset();
        rst = 1'b1; sx = 10'd100; sy = 10'd100; row_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk(msg_idx == 0, "R1 idx", msg_idx, 0);
        chk(msg_addr == 0, "R1 msg_addr", msg_addr, 0);
        chk(font_addr == 0, "R1 font_addr", font_addr, 0);
        chk(slot_strobe == 0, "R1 strobe", slot_strobe, 0);
    endtask

    // Sweep one blanking start on row y and check every scheduled cycle
    task automatic sweep_line(input int y, input int seed);
        int lo;
        int fa;
        lo = (y >= ROW2_Y) ? SLOTS : 0;
        for (int s = 0; s < SLOTS; s++) row_idx[s*3 +: 3] = 3'((s * 3 + seed) % 8);
        for (int x = H_ACTIVE - 4; x < H_ACTIVE + SLOTS + 6; x++) begin
            step(x, y);
            if (x >= H_ACTIVE && x < H_ACTIVE + SLOTS) begin
                if (lo != 0)
                    chk(msg_addr == 9'(exp_idx*16 + (x-H_ACTIVE) + 8), "R3 msg_addr",
                        msg_addr, exp_idx*16 + (x-H_ACTIVE) + 8);
                else
                    chk(msg_addr == 9'(exp_idx*16 + (x-H_ACTIVE)), "R2 msg_addr",
                        msg_addr, exp_idx*16 + (x-H_ACTIVE));
            end else begin
                chk(msg_addr == 0, "R4 msg_addr idle", msg_addr, 0);
            end
            if (x >= H_ACTIVE + 2 && x < H_ACTIVE + SLOTS + 2) begin
                int i;
                i = x - H_ACTIVE - 2;
                chk(slot_strobe == 8'(1 << i), "R5 strobe", slot_strobe, 1 << i);
                fa = (int'(msg_mem[exp_idx*16 + i + lo]) - 'h20) * 8 + int'(row_idx[i*3 +: 3]);
                chk(font_addr == 9'(fa), "R6 font_addr", font_addr, fa);
            end else begin
                chk(slot_strobe == 0, "R5 strobe idle", slot_strobe, 0);
                chk(font_addr == 0, "R7 font_addr idle", font_addr, 0);
            end
            chk(msg_idx == 5'(exp_idx), "R9 idx steady in line", msg_idx, exp_idx);
        end
    endtask

    task automatic frame_tick();
        step(0, 0);
        step(1, 0);
        exp_fcnt++;
        if (exp_fcnt == FRAMES) begin
            exp_fcnt = 0;
            exp_idx = (exp_idx + 1) % MSGS;
        end
        chk(msg_idx == 5'(exp_idx), "R8 idx after frame", msg_idx, exp_idx);
    endtask

    task automatic test_rotation(input int frames);
        for (int f = 0; f < frames; f++) frame_tick();
    endtask

    initial begin
        for (int a = 0; a < 512; a++) msg_mem[a] = 7'('h20 + ((a * 7 + 3) % 64));
        sx = '0; sy = '0; row_idx = '0; rst = 1'b1;
        test_reset();
        sweep_line(10, 0);
        sweep_line(ROW2_Y - 1, 1);
        sweep_line(ROW2_Y, 2);
        sweep_line(400, 5);
        test_rotation(1);
        chk(msg_idx == 0, "R8 no advance before count", msg_idx, 0);
        test_rotation(5);
        sweep_line(20, 3);
        sweep_line(300, 6);
        test_rotation(2 * MSGS - 6);
        chk(msg_idx == 0, "R8 wrap to zero", msg_idx, 0);
        sweep_line(50, 7);
        sweep_line(ROW2_Y + 1, 4);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule